// File: doc/BRIEF.md
# Pause-Width Reader Bit Encoder

This block sends one reader-to-card frame by switching a carrier off and on. Each bit is a fixed carrier-off pause followed by a carrier-on stretch. The length of that stretch carries the bit value: a long stretch means 1 and a short stretch means 0. Before a bit is encoded, it is XORed with a keystream bit supplied from outside. The block pulses a strobe once per bit so that the external keystream generator steps to its next bit.

All timing is scheduled against a free-running absolute tick count (1.5 ticks per microsecond). A shared frame-end timestamp comes in with each start request. Every deadline is built by adding an interval to the running deadline, never to the current time, so rounding and latency do not add up across bits or across frames. When a frame ends, the final deadline is presented as the new frame-end timestamp, ready to be fed back for the next exchange. After the last data bit, one more pause marks the end of the frame.

Top module: `pause_width_tx`

## Requirements
- R1: After reset and whenever idle, `carrier_off`, `ks_step` and `done` are 0 and `frame_end_out` holds its last value (0 after reset).
- R2: The carrier-off edge of the first pause happens when `tick_now` reaches `frame_end_in` + 330, where `frame_end_in` is the value sampled with `start`.
- R3: Every pause, including the closing one, keeps `carrier_off` at 1 for exactly 30 ticks.
- R4: A symbol that carries 1 lasts 150 ticks from pause start to next pause start (120 ticks of carrier). A symbol that carries 0 lasts 90 ticks (60 ticks of carrier).
- R5: Bits go out from bit 0 of `frame_word` upward. The value sent for bit i is `frame_word[i]` XOR the `ks_bit` present when that bit's pause begins.
- R6: `ks_step` is a one-cycle pulse, raised in the cycle each data pause begins, exactly once per data bit.
- R7: The closing pause begins right after the last data symbol ends. When it ends, the carrier returns and `done` pulses for one cycle.
- R8: `frame_end_out` changes only with `done`. It then equals `frame_end_in` + 330 + the sum of all symbol lengths + 30.
- R9: A frame length of 0 sends only the closing pause, starting at `frame_end_in` + 330, with no `ks_step`.
- R10: A `frame_len` above FRAME_W (32) is treated as FRAME_W.
- R11: A `start` that arrives while a frame is in progress is ignored. The running frame's timing and result are unchanged.
- R12: Deadlines are compared modulo 2^TS_W, so a frame that spans the wrap of `tick_now` keeps exact timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_now | input | TS_W | Free-running absolute tick count |
| start | input | 1 | Begin a frame (sampled while idle) |
| frame_word | input | FRAME_W | Frame bits, bit 0 sent first |
| frame_len | input | LEN_W | Number of bits to send |
| ks_bit | input | 1 | Current keystream bit |
| frame_end_in | input | TS_W | Shared frame-end timestamp |
| carrier_off | output | 1 | 1 = carrier off (pause) |
| ks_step | output | 1 | Advance keystream by one step |
| frame_end_out | output | TS_W | Updated frame-end timestamp |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The in-line properties assume that the keystream source answers `ks_step` before the next pause begins. They also assume that `frame_end_in` + 330 lies in the future when `start` is given. The bench keeps to both conditions. It steps its keystream index on every `ks_step`, and it always sets the timestamp either a few ticks ahead of the present count or to the previous frame's end. The bench advances `tick_now` by exactly one tick per clock, so every interval can be checked to the exact cycle. The count starts a few thousand ticks below its wrap point, so several frames cross the wrap.

// File: rtl/pwe_pkg.sv
package pwe_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LEAD  = 3'd1,
        ST_PAUSE = 3'd2,
        ST_MARK  = 3'd3,
        ST_CLOSE = 3'd4
    } pwe_state_e;

endpackage

// File: rtl/pwe_due.sv
module pwe_due #(
    parameter int TS_W = 32
) (
    input  logic [TS_W-1:0] now_i,
    input  logic [TS_W-1:0] deadline_i,
    output logic            due_o
);

    logic signed [TS_W-1:0] gap;

    // Modular difference: the deadline is reached once now is not behind it.
    always_comb begin
        gap   = $signed(now_i - deadline_i);
        due_o = (gap >= 0);
    end

endmodule

// File: rtl/pwe_interval.sv
module pwe_interval #(
    parameter int TS_W       = 32,
    parameter int TICKS_GAP  = 330,
    parameter int TICKS_PAUSE = 30,
    parameter int TICKS_ONE  = 150,
    parameter int TICKS_ZERO = 90
) (
    input  logic            tx_bit_i,
    output logic [TS_W-1:0] gap_ticks_o,
    output logic [TS_W-1:0] pause_ticks_o,
    output logic [TS_W-1:0] mark_ticks_o
);

    localparam int MARK_ONE  = TICKS_ONE - TICKS_PAUSE;
    localparam int MARK_ZERO = TICKS_ZERO - TICKS_PAUSE;

    assign gap_ticks_o   = TS_W'(TICKS_GAP);
    assign pause_ticks_o = TS_W'(TICKS_PAUSE);
    assign mark_ticks_o  = tx_bit_i ? TS_W'(MARK_ONE) : TS_W'(MARK_ZERO);

endmodule

// File: rtl/pwe_bit_pick.sv
module pwe_bit_pick #(
    parameter int FRAME_W = 32,
    parameter int LEN_W   = 6
) (
    input  logic [FRAME_W-1:0] word_i,
    input  logic [LEN_W-1:0]   idx_i,
    input  logic               ks_i,
    output logic               tx_bit_o
);

    logic [FRAME_W-1:0] hit;

    for (genvar g = 0; g < FRAME_W; g++) begin : g_sel
        assign hit[g] = word_i[g] & (idx_i == LEN_W'(g));
    end

    // Whitening: data bit XOR current keystream bit.
    assign tx_bit_o = (|hit) ^ ks_i;

endmodule

// File: rtl/pause_width_tx.sv
module pause_width_tx
    import pwe_pkg::*;
#(
    parameter int TS_W        = 32,
    parameter int FRAME_W     = 32,
    parameter int LEN_W       = $clog2(FRAME_W + 1),
    parameter int TICKS_GAP   = 330,
    parameter int TICKS_PAUSE = 30,
    parameter int TICKS_ONE   = 150,
    parameter int TICKS_ZERO  = 90
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TS_W-1:0]    tick_now,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame_word,
    input  logic [LEN_W-1:0]   frame_len,
    input  logic               ks_bit,
    input  logic [TS_W-1:0]    frame_end_in,
    output logic               carrier_off,
    output logic               ks_step,
    output logic [TS_W-1:0]    frame_end_out,
    output logic               done
);

    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(FRAME_W);

    typedef struct packed {
        pwe_state_e         state;
        logic [FRAME_W-1:0] word;
        logic [LEN_W-1:0]   len;
        logic [LEN_W-1:0]   idx;
        logic               tx_bit;
        logic [TS_W-1:0]    deadline;
        logic [TS_W-1:0]    frame_end;
        logic               carrier_off;
        logic               ks_step;
        logic               done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic               due;
    logic [LEN_W-1:0]   sym_idx_d;
    logic               sym_last_d;
    logic               sym_bit_d;
    logic [LEN_W-1:0]   len_clamped_d;
    logic [TS_W-1:0]    gap_ticks, pause_ticks, mark_ticks;

    // Index of the symbol that would begin now, and whether the data is used up.
    always_comb begin
        sym_idx_d     = (ctl_q.state == ST_MARK) ? ctl_q.idx + LEN_W'(1) : '0;
        sym_last_d    = (sym_idx_d == ctl_q.len);
        len_clamped_d = (frame_len > LEN_MAX) ? LEN_MAX : frame_len;
    end

    pwe_due #(.TS_W(TS_W)) i_due (
        .now_i      (tick_now),
        .deadline_i (ctl_q.deadline),
        .due_o      (due)
    );

    pwe_interval #(
        .TS_W        (TS_W),
        .TICKS_GAP   (TICKS_GAP),
        .TICKS_PAUSE (TICKS_PAUSE),
        .TICKS_ONE   (TICKS_ONE),
        .TICKS_ZERO  (TICKS_ZERO)
    ) i_interval (
        .tx_bit_i      (ctl_q.tx_bit),
        .gap_ticks_o   (gap_ticks),
        .pause_ticks_o (pause_ticks),
        .mark_ticks_o  (mark_ticks)
    );

    pwe_bit_pick #(.FRAME_W(FRAME_W), .LEN_W(LEN_W)) i_pick (
        .word_i   (ctl_q.word),
        .idx_i    (sym_idx_d),
        .ks_i     (ks_bit),
        .tx_bit_o (sym_bit_d)
    );

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.ks_step = 1'b0;
        ctl_d.done    = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (start) begin
                    ctl_d.state    = ST_LEAD;
                    ctl_d.word     = frame_word;
                    ctl_d.len      = len_clamped_d;
                    ctl_d.idx      = '0;
                    ctl_d.deadline = frame_end_in + gap_ticks;
                end
            end
            ST_LEAD, ST_MARK: begin
                if (due) begin
                    ctl_d.carrier_off = 1'b1;
                    ctl_d.deadline    = ctl_q.deadline + pause_ticks;
                    if (sym_last_d) begin
                        ctl_d.state = ST_CLOSE;
                    end else begin
                        ctl_d.state   = ST_PAUSE;
                        ctl_d.idx     = sym_idx_d;
                        ctl_d.tx_bit  = sym_bit_d;
                        ctl_d.ks_step = 1'b1;
                    end
                end
            end
            ST_PAUSE: begin
                if (due) begin
                    ctl_d.state       = ST_MARK;
                    ctl_d.carrier_off = 1'b0;
                    ctl_d.deadline    = ctl_q.deadline + mark_ticks;
                end
            end
            ST_CLOSE: begin
                if (due) begin
                    ctl_d.state       = ST_IDLE;
                    ctl_d.carrier_off = 1'b0;
                    ctl_d.done        = 1'b1;
                    ctl_d.frame_end   = ctl_q.deadline;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign carrier_off   = ctl_q.carrier_off;
    assign ks_step       = ctl_q.ks_step;
    assign frame_end_out = ctl_q.frame_end;
    assign done          = ctl_q.done;

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_carrier_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !carrier_off);

    p_ks_in_pause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ks_step |-> carrier_off);

    p_ks_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ks_step |=> !ks_step);

    p_end_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(frame_end_out));

endmodule

// File: tb/test_pause_width_tx.sv
module test_pause_width_tx;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    localparam logic [31:0] TICK_BASE = 32'hFFFF_FFFF - 32'd4000;

    localparam logic [31:0] V_WORD [NVEC] = '{32'h0000_0001, 32'h0000_0019,
        32'hA5C3_1F0E, 32'h0000_1234, 32'hFFFF_FFFF, 32'h0000_00FF};
    localparam logic [5:0]  V_LEN  [NVEC] = '{6'd7, 6'd6, 6'd32, 6'd13, 6'd40, 6'd0};
    localparam logic [31:0] V_KS   [NVEC] = '{32'h0000_0055, 32'h0000_003F,
        32'h0000_0000, 32'h0000_0FFF, 32'h1234_5678, 32'h0000_0000};
    localparam bit          V_CHAIN[NVEC] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] tick_now;
    logic        start = 1'b0;
    logic [31:0] frame_word = '0;
    logic [5:0]  frame_len = '0;
    logic        ks_bit;
    logic [31:0] frame_end_in = '0;
    logic        carrier_off, ks_step, done;
    logic [31:0] frame_end_out;

    int          checks = 0;
    int          errors = 0;
    logic [31:0] edges [80];
    int          n_edges = 0;
    int          ks_cnt = 0;
    int          done_cnt = 0;
    logic [31:0] cur_ks = '0;
    logic [5:0]  ks_idx = '0;
    logic        prev_co = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_ff @(posedge clk) begin
        if (!rst_n) tick_now <= TICK_BASE;
        else        tick_now <= tick_now + 32'd1;
    end

    assign ks_bit = cur_ks[ks_idx[4:0]];

    pause_width_tx i_pause_width_tx (
        .clk(clk), .rst_n(rst_n), .tick_now(tick_now), .start(start),
        .frame_word(frame_word), .frame_len(frame_len), .ks_bit(ks_bit),
        .frame_end_in(frame_end_in), .carrier_off(carrier_off), .ks_step(ks_step),
        .frame_end_out(frame_end_out), .done(done)
    );

    // Monitor: edge times are the tick the design saw at the changing edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (carrier_off !== prev_co) begin
                if (n_edges < 80) edges[n_edges] = tick_now - 32'd1;
                n_edges++;
            end
            prev_co = carrier_off;
            if (ks_step) begin ks_cnt++; ks_idx = ks_idx + 6'd1; end
            if (done) done_cnt++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_frame(input logic [31:0] w, input logic [5:0] l,
                             input logic [31:0] ks, input logic [31:0] fin,
                             input bit poke, input string req);
        int          eff;
        logic [31:0] t;
        logic [31:0] exp_e [80];
        int          bad;
        int          guard;
        eff = (l > 6'd32) ? 32 : int'(l);
        t = fin + 32'd330;
        for (int i = 0; i < eff; i++) begin
            exp_e[2*i]   = t;
            exp_e[2*i+1] = t + 32'd30;
            t = t + ((w[i] ^ ks[i]) ? 32'd150 : 32'd90);
        end
        exp_e[2*eff]   = t;
        exp_e[2*eff+1] = t + 32'd30;
        n_edges = 0; ks_cnt = 0; done_cnt = 0; ks_idx = '0; cur_ks = ks;
        frame_word = w; frame_len = l; frame_end_in = fin; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            frame_word = ~w; frame_len = 6'd5; frame_end_in = fin + 32'd1000; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (done_cnt == 0 && guard < 20000) begin @(negedge clk); guard++; end
        repeat (3) @(negedge clk);
        check(guard < 20000, req, "frame completed before timeout", guard, 0);
        check(n_edges == 2*(eff+1), req, "R5 R7 carrier edge count", n_edges, 2*(eff+1));
        bad = -1;
        for (int k = 0; k < 2*(eff+1) && k < n_edges; k++)
            if (bad < 0 && (k % 2 == 0) && edges[k] !== exp_e[k]) bad = k;
        check(bad < 0, req, "R2 R4 R5 R12 pause start tick",
              bad < 0 ? 0 : edges[bad], bad < 0 ? 0 : exp_e[bad]);
        bad = -1;
        for (int k = 1; k < 2*(eff+1) && k < n_edges; k += 2)
            if (bad < 0 && edges[k] !== exp_e[k]) bad = k;
        check(bad < 0, req, "R3 pause end tick",
              bad < 0 ? 0 : edges[bad], bad < 0 ? 0 : exp_e[bad]);
        check(ks_cnt == eff, req, "R6 keystream steps", ks_cnt, eff);
        check(done_cnt == 1, req, "R7 done pulses", done_cnt, 1);
        check(frame_end_out == exp_e[2*eff+1], req, "R8 frame end", frame_end_out, exp_e[2*eff+1]);
        check(carrier_off == 1'b0, req, "R1 carrier on after frame", carrier_off, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] fin;
        repeat (4) @(negedge clk);
        check(carrier_off == 1'b0, "R1", "reset carrier_off", carrier_off, 0);
        check(ks_step == 1'b0, "R1", "reset ks_step", ks_step, 0);
        check(done == 1'b0, "R1", "reset done", done, 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check(frame_end_out == 32'd0, "R1", "idle frame_end_out", frame_end_out, 0);
        check(carrier_off == 1'b0, "R1", "idle carrier_off", carrier_off, 0);

        // Table walk: R2..R10 and R12 (tick count wraps during these frames).
        for (int v = 0; v < NVEC; v++) begin
            fin = V_CHAIN[v] ? frame_end_out : tick_now + 32'd10;
            run_frame(V_WORD[v], V_LEN[v], V_KS[v], fin, 1'b0,
                      (V_LEN[v] == 0) ? "R9" : (V_LEN[v] > 32) ? "R10" : "R12");
        end

        // R11: second start during the lead gap must not disturb the frame.
        run_frame(32'h0000_00B6, 6'd8, 32'h0000_000F, tick_now + 32'd10, 1'b1, "R11");
        // Chained short frame after the ignored start.
        run_frame(32'h0000_0002, 6'd2, 32'h0000_0003, frame_end_out, 1'b0, "R8");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule